// File: doc/BRIEF.md
# Bus-Attached Seconds Counter with Match Alarm

This block is a real-time clock peripheral that sits on a simple APB-style register bus. An internal prescaler divides the input clock down to a one-second strobe. Each strobe advances a free-running 32-bit seconds count by one. Software can set the count to any value through a load register. It can also program a match value; when the count steps onto that value, an alarm flag is latched.

The alarm flag drives the interrupt output through a one-bit mask. A write of any data to the clear register drops the flag. Software can read back the count, the match and load values, the mask, and both the raw and masked alarm status. A constant control word reports that the counter is always running. Eight identification bytes can be read, one per word, from the top window of the 4 KiB register space.

Bus transfers use a setup cycle (select high, enable low) and then an access cycle (select and enable high). Writes take effect on the clock edge that ends the access cycle. Read data is combinational from the address while select is high and write is low, and it is zero at all other times.

Top module: `rtc_sec_top`

## Requirements
- R1: After reset, the count, match, load, mask and alarm flag are all zero, and the interrupt output is low.
- R2: The count at offset 0x00 advances by one, modulo 2^32, once every TICK_DIV clocks. The first step happens on the TICK_DIV-th rising edge after reset is released.
- R3: A write to offset 0x08 sets the count to the written data on the same edge. It also sets the value read back at 0x08. If a one-second step falls on that edge, the load wins.
- R4: Offset 0x04 reads back the last match value written. Offset 0x10 returns the last mask bit written (write data bit 0) in bit 0, and zero in bits 31:1.
- R5: The alarm flag, read at offset 0x14 bit 0, is set on the edge where a one-second step moves the count onto the match value, including a step that wraps past 0xFFFFFFFF. A load write or a match write that makes the two equal does not set the flag.
- R6: Once set, the alarm flag stays set until a write to offset 0x1C, which clears it whatever the data. If a write to 0x1C and an alarm-setting step fall on the same edge, the flag ends set.
- R7: The interrupt output equals the alarm flag ANDed with the mask bit. Offset 0x18 returns that same value in bit 0, and zero in bits 31:1.
- R8: Offset 0x0C always reads 1, and writes to it change nothing.
- R9: A read at offsets 0xFE0 through 0xFFC returns, in bits 7:0, the byte selected by (offset-0xFE0)>>2 from the list 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1, with zero in bits 31:8.
- R10: A read of any other offset, including 0x1C, returns zero. A write to 0x00, 0x14, 0x18 or any undefined offset changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access-phase strobe |
| pwrite | input | 1 | 1 for a write transfer, 0 for a read |
| paddr | input | ADDR_W | Byte offset into the register space |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, zero when no read is selected |
| irq | output | 1 | Alarm interrupt, raw flag ANDed with mask |

## Verification
The bench drives the count across the 0xFFFFFFFF to 0 wrap with the match set to zero. A design that compares magnitudes, or that stops at the top, would never raise the alarm there. It loads the count to the match value and writes the match equal to the running count. A design that compares levels instead of detecting a step would raise a false alarm. It issues back-to-back clear writes whose period is prime to the tick period, so that one clear lands on the alarm step; a design that lets the clear win would lose an alarm. It also writes to the read-only, control and undefined offsets and reads everything back, which catches a decoder that aliases addresses or drops the control and identification words.

// File: rtl/rtc_sec_pkg.sv
package rtc_sec_pkg;

    localparam int unsigned RTC_W = 32;

    // Byte offsets decoded by software drivers.
    localparam logic [11:0] OFS_COUNT = 12'h000;
    localparam logic [11:0] OFS_MATCH = 12'h004;
    localparam logic [11:0] OFS_LOAD  = 12'h008;
    localparam logic [11:0] OFS_CTRL  = 12'h00C;
    localparam logic [11:0] OFS_MASK  = 12'h010;
    localparam logic [11:0] OFS_RAW   = 12'h014;
    localparam logic [11:0] OFS_MSKD  = 12'h018;
    localparam logic [11:0] OFS_CLEAR = 12'h01C;

    // Identification window 0xFE0..0xFFF: offset bits 11:5 all ones.
    localparam logic [6:0] ID_WINDOW = 7'h7F;

    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        logic [7:0] b;
        case (idx)
            3'd0:    b = 8'h31;
            3'd1:    b = 8'h10;
            3'd2:    b = 8'h14;
            3'd3:    b = 8'h00;
            3'd4:    b = 8'h0D;
            3'd5:    b = 8'hF0;
            3'd6:    b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

    typedef struct packed {
        logic [RTC_W-1:0] match;
        logic [RTC_W-1:0] load;
        logic             mask;
        logic             raw;
    } rtc_regs_t;

    typedef struct packed {
        logic [RTC_W-1:0] count;
    } rtc_cnt_t;

endpackage

// File: rtl/rtc_sec_prescaler.sv
module rtc_sec_prescaler #(
    parameter int unsigned TICK_DIV = 32768
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pre_t;

    pre_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = (st_q.cnt == LAST);

endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter
    import rtc_sec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load_en,
    input  logic [RTC_W-1:0] load_val,
    input  logic [RTC_W-1:0] match,
    output logic [RTC_W-1:0] count,
    output logic             hit
);
    rtc_cnt_t st_d, st_q;
    logic [RTC_W-1:0] stepped;

    always_comb begin
        st_d    = st_q;
        hit     = 1'b0;
        stepped = st_q.count + 1'b1;
        if (load_en) begin
            st_d.count = load_val;
        end else if (tick) begin
            st_d.count = stepped;
            hit        = (stepped == match);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.count;

endmodule

// File: rtl/rtc_sec_regs.sv
module rtc_sec_regs
    import rtc_sec_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [RTC_W-1:0]  pwdata,
    input  logic [RTC_W-1:0]  count,
    input  logic              hit,
    output logic [RTC_W-1:0]  prdata,
    output logic              irq,
    output logic              load_en,
    output logic [RTC_W-1:0]  load_val,
    output logic [RTC_W-1:0]  match,
    output logic              raw
);
    rtc_regs_t   st_d, st_q;
    logic [11:0] ofs;
    logic        wr_acc;
    logic        rd_sel;
    logic        clr_wr;

    assign ofs    = paddr[11:0];
    assign wr_acc = psel & penable & pwrite;
    assign rd_sel = psel & ~pwrite;
    assign clr_wr = wr_acc && (ofs == OFS_CLEAR);

    always_comb begin
        st_d = st_q;
        if (wr_acc) begin
            case (ofs)
                OFS_MATCH: st_d.match = pwdata;
                OFS_LOAD:  st_d.load  = pwdata;
                OFS_MASK:  st_d.mask  = pwdata[0];
                default:   ;
            endcase
        end
        if (clr_wr) begin
            st_d.raw = 1'b0;
        end
        if (hit) begin
            st_d.raw = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        prdata = '0;
        if (rd_sel) begin
            if (ofs[11:5] == ID_WINDOW) begin
                prdata[7:0] = id_byte(ofs[4:2]);
            end else begin
                case (ofs)
                    OFS_COUNT: prdata    = count;
                    OFS_MATCH: prdata    = st_q.match;
                    OFS_LOAD:  prdata    = st_q.load;
                    OFS_CTRL:  prdata[0] = 1'b1;
                    OFS_MASK:  prdata[0] = st_q.mask;
                    OFS_RAW:   prdata[0] = st_q.raw;
                    OFS_MSKD:  prdata[0] = st_q.raw & st_q.mask;
                    default:   prdata    = '0;
                endcase
            end
        end
    end

    assign load_en  = wr_acc && (ofs == OFS_LOAD);
    assign load_val = pwdata;
    assign match    = st_q.match;
    assign raw      = st_q.raw;
    assign irq      = st_q.raw & st_q.mask;

endmodule

// File: rtl/rtc_sec_top.sv
module rtc_sec_top #(
    parameter int unsigned TICK_DIV = 32768,
    parameter int unsigned ADDR_W   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              irq
);
    logic        w_tick;
    logic        w_load_en;
    logic [31:0] w_load_val;
    logic [31:0] w_match;
    logic [31:0] w_count;
    logic        w_hit;
    logic        w_raw;

    rtc_sec_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (w_tick)
    );

    rtc_sec_counter u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (w_tick),
        .load_en  (w_load_en),
        .load_val (w_load_val),
        .match    (w_match),
        .count    (w_count),
        .hit      (w_hit)
    );

    rtc_sec_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .psel     (psel),
        .penable  (penable),
        .pwrite   (pwrite),
        .paddr    (paddr),
        .pwdata   (pwdata),
        .count    (w_count),
        .hit      (w_hit),
        .prdata   (prdata),
        .irq      (irq),
        .load_en  (w_load_en),
        .load_val (w_load_val),
        .match    (w_match),
        .raw      (w_raw)
    );

endmodule

// File: rtl/rtc_sec_checker.sv
module rtc_sec_checker #(
    parameter int unsigned ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [31:0]       pwdata,
    input logic [31:0]       prdata,
    input logic              irq,
    input logic [31:0]       count,
    input logic              raw,
    input logic              tick
);
    logic [11:0] ofs;
    logic        wr_acc;
    logic        rd_sel;
    logic        ld_wr;
    logic        clr_wr;

    assign ofs    = paddr[11:0];
    assign wr_acc = psel & penable & pwrite;
    assign rd_sel = psel & ~pwrite;
    assign ld_wr  = wr_acc && (ofs == 12'h008);
    assign clr_wr = wr_acc && (ofs == 12'h01C);

    assert_count_moves_on_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(count) |-> $past(tick || ld_wr));

    assert_load_takes_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ld_wr |=> (count == $past(pwdata)));

    assert_raw_set_by_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw) |-> $past(tick));

    assert_raw_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (raw && !clr_wr) |=> raw);

    assert_clear_drops_raw_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !tick) |=> !raw);

    assert_masked_read_matches_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel && ofs == 12'h018) |-> (prdata == {31'b0, irq}));

    assert_ctrl_reads_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel && ofs == 12'h00C) |-> (prdata == 32'd1));

endmodule

bind rtc_sec_top rtc_sec_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .pwdata  (pwdata),
    .prdata  (prdata),
    .irq     (irq),
    .count   (w_count),
    .raw     (w_raw),
    .tick    (w_tick)
);

// File: tb/rtc_sec_top_tb.sv
`timescale 1ns/100ps
module rtc_sec_top_tb;
    localparam int unsigned DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    string cur_tag = "R1";

    // reference model state
    int unsigned pre     = 0;
    logic [31:0] m_count = '0;
    logic [31:0] m_match = '0;
    logic [31:0] m_load  = '0;
    bit          m_mask  = 1'b0;
    bit          m_raw   = 1'b0;

    always #2.5 clk = ~clk;

    rtc_sec_top #(.TICK_DIV(DIV), .ADDR_W(12)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pwdata  (pwdata),
        .prdata  (prdata),
        .irq     (irq)
    );

    // behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        bit          tk;
        bit          wr;
        bit          hit;
        logic [31:0] nxt;
        if (!rst_n) begin
            pre = 0; m_count = '0; m_match = '0; m_load = '0; m_mask = 0; m_raw = 0;
        end else begin
            tk  = (pre == DIV - 1);
            wr  = psel && penable && pwrite;
            hit = 1'b0;
            pre = tk ? 0 : pre + 1;
            if (wr && paddr == 12'h008) begin
                m_count = pwdata;
                m_load  = pwdata;
            end else if (tk) begin
                nxt = m_count + 32'd1;
                hit = (nxt == m_match);
                m_count = nxt;
            end
            if (wr && paddr == 12'h004) m_match = pwdata;
            if (wr && paddr == 12'h010) m_mask  = pwdata[0];
            if (wr && paddr == 12'h01C) m_raw   = 1'b0;
            if (hit) m_raw = 1'b1;
        end
    end

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        logic [7:0] ids [8];
        ids = '{8'h31, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        if (a >= 12'hFE0) return {24'b0, ids[(a - 12'hFE0) >> 2]};
        case (a)
            12'h000: return m_count;
            12'h004: return m_match;
            12'h008: return m_load;
            12'h00C: return 32'd1;
            12'h010: return {31'b0, m_mask};
            12'h014: return {31'b0, m_raw};
            12'h018: return {31'b0, m_raw & m_mask};
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h at %0t", tag, got, exp, $time);
        end
    endtask

    // compare against the model every cycle, away from the rising edge
    always @(negedge clk) begin
        if (!done) begin
            check("R7 irq", {31'b0, irq}, {31'b0, rst_n ? (m_raw & m_mask) : 1'b0});
            if (psel && penable && !pwrite) begin
                check(cur_tag, prdata, exp_read(paddr));
            end
        end
    end

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(posedge clk); #1;
        penable = 1;
        @(posedge clk); #1;
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic bus_rd(input logic [11:0] a, input string tag);
        @(posedge clk); #1;
        cur_tag = tag;
        psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(posedge clk); #1;
        penable = 1;
        @(posedge clk); #1;
        psel = 0; penable = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state is visible before the first step
        check("R1 count after reset", prdata, 32'd0);
        check("R1 irq after reset", {31'b0, irq}, 32'd0);
        rst_n = 1'b1;
        bus_rd(12'h000, "R1 count");
        bus_rd(12'h004, "R1 match");
        bus_rd(12'h008, "R1 load");
        bus_rd(12'h010, "R1 mask");
        bus_rd(12'h014, "R1 raw");
        bus_rd(12'h00C, "R8 ctrl");
        for (int i = 0; i < 8; i++) bus_rd(12'hFE0 + 12'(i * 4), "R9 id");
        bus_rd(12'h01C, "R10 clear reads zero");
        bus_rd(12'h020, "R10 undefined");
        bus_rd(12'h800, "R10 undefined");

        // R2: free running count
        idle(5 * DIV);
        bus_rd(12'h000, "R2 count");
        idle(DIV + 1);
        bus_rd(12'h000, "R2 count");

        // R3: load
        bus_wr(12'h008, 32'h0000_0100);
        bus_rd(12'h008, "R3 load readback");
        bus_rd(12'h000, "R3 count after load");

        // R4 + R5: match ahead, then unmask (R7)
        bus_wr(12'h004, m_count + 32'd3);
        bus_rd(12'h004, "R4 match readback");
        idle(5 * DIV);
        bus_rd(12'h014, "R5 raw after match");
        bus_rd(12'h018, "R7 masked while mask off");
        bus_wr(12'h010, 32'h0000_0001);
        bus_rd(12'h010, "R4 mask readback");
        bus_rd(12'h018, "R7 masked status");
        check("R5 raw latched", {31'b0, m_raw}, 32'd1);

        // R10 / R8: ignored writes
        bus_wr(12'h000, 32'h1234_5678);
        bus_wr(12'h014, 32'h0);
        bus_wr(12'h018, 32'h0);
        bus_wr(12'h00C, 32'h0);
        bus_wr(12'h040, 32'hFFFF_FFFF);
        bus_wr(12'hFE0, 32'h0);
        bus_rd(12'h000, "R10 count untouched");
        bus_rd(12'h014, "R10 raw untouched");
        bus_rd(12'h00C, "R8 ctrl after write");
        bus_rd(12'hFE0, "R9 id after write");
        bus_rd(12'h004, "R10 match untouched");

        // R6: clear with zero data
        bus_wr(12'h01C, 32'h0);
        bus_rd(12'h014, "R6 raw cleared");
        bus_rd(12'h018, "R6 masked cleared");

        // R5: load onto match value or match onto count does not fire
        bus_wr(12'h008, m_match);
        idle(2);
        bus_wr(12'h004, m_count);
        idle(2 * DIV);
        bus_rd(12'h014, "R5 no alarm from writes");

        // R5: wrap-around alarm
        bus_wr(12'h004, 32'h0000_0000);
        bus_wr(12'h008, 32'hFFFF_FFFE);
        idle(DIV);
        bus_rd(12'h014, "R5 before wrap");
        idle(3 * DIV);
        bus_rd(12'h014, "R5 after wrap");
        bus_rd(12'h000, "R2 count after wrap");

        // R6: clear colliding with an alarm step
        bus_wr(12'h01C, 32'hA5);
        bus_wr(12'h008, 32'h50);
        bus_wr(12'h004, 32'h52);
        for (int i = 0; i < 12; i++) bus_wr(12'h01C, 32'hA5A5_0000 + 32'(i));
        bus_rd(12'h014, "R6 set wins over clear");
        bus_wr(12'h004, m_count + 32'd2);
        for (int i = 0; i < 12; i++) bus_wr(12'h01C, 32'hFFFF_FFFF);
        bus_rd(12'h014, "R6 set wins over clear");

        // R4: mask uses bit 0 only
        bus_wr(12'h010, 32'hFFFF_FFFE);
        bus_rd(12'h010, "R4 mask bit0 clear");
        bus_wr(12'h010, 32'hFFFF_FFFF);
        bus_rd(12'h010, "R4 mask bit0 set");
        bus_rd(12'h018, "R7 masked final");

        idle(4);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule